// File: doc/BRIEF.md
# Synchronous Character Transmitter with CRC-16 Trailer

This block is a single-channel serial transmit engine. Software-side logic writes bytes into a one-entry holding buffer. On each transmit bit enable the engine either shifts the next bit of the current character onto the serial line or, once a character is finished, starts a new one. It fetches the next character from the buffer if one is waiting. If the buffer is empty it treats the gap as an underrun and sends either an accumulated CRC-16 trailer or a fixed idle/sync byte.

A control word sets the transmitter on or off, forces a break (a continuous low line), enables CRC accumulation and selects the character length. Lengths of six, seven and eight bits are chosen directly by the select. With the select at zero, each written byte carries its own length as a run of leading ones. Turning the transmitter off lets a data or sync character run to its end. A CRC trailer in flight is dropped instead, and a sync byte is sent in its place.

Top module: `sync_tx_engine`

## Requirements
- R1: With transmit enable low and no character in progress, each bit enable drives txd high; txd and buf_empty are 1 out of reset.
- R2: Length select 1, 2 and 3 send 6, 7 and 8 bits of the loaded byte, LSB first, one bit per bit enable; the first bit appears on the bit enable that loads the character.
- R3: Length select 0 decodes the byte: top four bits 1111 sends 1 bit; otherwise top three 111 sends 2; otherwise top two 11 sends 3; otherwise bit 7 set sends 4; otherwise 5 bits. The data are the low-order bits.
- R4: While break is set, txd is 0 from the next bit enable on, whether or not the transmitter is enabled. Shifting continues underneath, so clearing break shows the current shift contents again.
- R5: Clearing transmit enable in the middle of a data or sync character lets that character complete; txd then idles high.
- R6: On an underrun with CRC enable set and at least one CRC-included character sent since the last trailer, the 16-bit CRC is sent LSB first. The CRC is CRC-CCITT, polynomial 0x1021, preset 0xFFFF, updated MSB-shifted over the data bits in transmit order. The CRC register returns to preset once the trailer starts.
- R7: On an underrun in any other case, the sync byte 0x7E is sent LSB first.
- R8: CRC inclusion of a character is decided by CRC enable at the moment that character is loaded, not by later changes.
- R9: Clearing transmit enable during a CRC trailer drops the remaining CRC bits. A sync byte starts on the next bit enable, the CRC returns to preset, and the line then idles high.
- R10: buf_empty is 1 when the holding buffer can accept a byte; a write while it is full is ignored and the first byte is kept.
- R11: The channel reset and the hardware reset both clear transmit enable, break, the holding buffer and any character in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset |
| bit_en | input | 1 | Transmit bit enable, one bit per pulse |
| ctl_wr | input | 1 | Loads the control word below |
| ctl_tx_en | input | 1 | Transmit enable |
| ctl_brk | input | 1 | Send break |
| ctl_crc_en | input | 1 | CRC enable |
| ctl_len_sel | input | 2 | Length select: 0 marker-coded, 1/2/3 = 6/7/8 bits |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte written to the holding buffer |
| buf_empty | output | 1 | Holding buffer can take a byte |
| txd | output | 1 | Serial data out |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a 16-bit CRC with polynomial 0x1021 and preset 0xFFFF, and the 0x7E sync byte. At that size every byte value fits in a full sweep at 8 bits and again under marker-coded lengths, so each marker decode and every data bit position is compared against arithmetic in the bench. The 16-bit trailer is short enough to compute per frame in the bench. That makes mid-trailer disable, CRC latching at load and the preset return observable bit by bit on txd.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
   typedef enum logic [1:0] {
      K_IDLE = 2'd0,
      K_DATA = 2'd1,
      K_CRC  = 2'd2,
      K_SYNC = 2'd3
   } tx_kind_e;
endpackage

// File: rtl/sync_tx_len_decode.sv
module sync_tx_len_decode #(
   parameter int CHAR_W = 8,
   parameter int LEN_W  = 4
) (
   input  logic [1:0]        len_sel,
   input  logic [CHAR_W-1:0] raw,
   output logic [LEN_W-1:0]  len,
   output logic [CHAR_W-1:0] data
);
   logic [3:0] top_nib;
   assign top_nib = raw[CHAR_W-1 -: 4];

   always_comb begin
      case (len_sel)
         2'd1:    len = LEN_W'(CHAR_W - 2);
         2'd2:    len = LEN_W'(CHAR_W - 1);
         2'd3:    len = LEN_W'(CHAR_W);
         default: begin
            if (top_nib == 4'b1111)      len = LEN_W'(1);
            else if (top_nib[3:1] == 3'b111) len = LEN_W'(2);
            else if (top_nib[3:2] == 2'b11)  len = LEN_W'(3);
            else if (top_nib[3])             len = LEN_W'(4);
            else                             len = LEN_W'(5);
         end
      endcase
   end

   for (genvar g = 0; g < CHAR_W; g++) begin : g_mask
      assign data[g] = (LEN_W'(g) < len) ? raw[g] : 1'b0;
   end
endmodule

// File: rtl/sync_tx_holdbuf.sv
module sync_tx_holdbuf #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [CHAR_W-1:0] wdata,
   input  logic              take,
   output logic              full,
   output logic [CHAR_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full  <= 1'b0;
         rdata <= '0;
      end else if (clr) begin
         full  <= 1'b0;
         rdata <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr && !full) begin
         full  <= 1'b1;
         rdata <= wdata;
      end
   end

   AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full && !take && !clr) |=> (full && $stable(rdata))); // R10
   AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full); // R2
endmodule

// File: rtl/sync_tx_crc.sv
module sync_tx_crc #(
   parameter int                CHAR_W   = 8,
   parameter int                LEN_W    = 4,
   parameter int                CRC_W    = 16,
   parameter logic [CRC_W-1:0]  CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic [CHAR_W-1:0] data,
   input  logic [LEN_W-1:0]  len,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] chain [CHAR_W+1];
   assign chain[0] = crc;

   for (genvar g = 0; g < CHAR_W; g++) begin : g_bit
      logic             fb;
      logic [CRC_W-1:0] stepped;
      assign fb        = chain[g][CRC_W-1] ^ data[g];
      assign stepped   = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      assign chain[g+1] = (LEN_W'(g) < len) ? stepped : chain[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= CRC_INIT;
      else if (clr) crc <= CRC_INIT;
      else if (add) crc <= chain[CHAR_W];
   end

   AST_CRC_BACK_TO_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc == CRC_INIT)); // R6
endmodule

// File: rtl/sync_tx_engine.sv
module sync_tx_engine
   import sync_tx_pkg::*;
#(
   parameter int               CHAR_W    = 8,
   parameter int               CRC_W     = 16,
   parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
   parameter logic [CHAR_W-1:0] SYNC_CHAR = 8'h7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              bit_en,
   input  logic              ctl_wr,
   input  logic              ctl_tx_en,
   input  logic              ctl_brk,
   input  logic              ctl_crc_en,
   input  logic [1:0]        ctl_len_sel,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   output logic              buf_empty,
   output logic              txd
);
   localparam int LEN_W = $clog2(CHAR_W + 1);
   localparam int SH_W  = CRC_W;
   localparam int CNT_W = $clog2(SH_W);

   if (CHAR_W != 8) begin : g_bad_char
      $error("sync_tx_engine: marker decode needs CHAR_W == 8");
   end
   if (CRC_W < CHAR_W) begin : g_bad_crc
      $error("sync_tx_engine: CRC_W must be at least CHAR_W");
   end

   // control word
   logic       tx_en_q, brk_q, crc_en_q;
   logic [1:0] len_sel_q;

   // shifter state
   logic [SH_W-1:0]  sh, sh_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   tx_kind_e         kind, kind_n;
   logic             pend, pend_n;
   logic             out_bit, txd_q;

   // datapath links
   logic              buf_full, take, crc_add, crc_clr;
   logic [CHAR_W-1:0] buf_data, dec_data;
   logic [LEN_W-1:0]  dec_len;
   logic [CRC_W-1:0]  crc_val;

   sync_tx_holdbuf #(.CHAR_W(CHAR_W)) hold_i (
      .clk(clk), .rst_n(rst_n), .clr(chan_rst), .wr(wr_en), .wdata(wr_data),
      .take(take), .full(buf_full), .rdata(buf_data));

   sync_tx_len_decode #(.CHAR_W(CHAR_W), .LEN_W(LEN_W)) dec_i (
      .len_sel(len_sel_q), .raw(buf_data), .len(dec_len), .data(dec_data));

   sync_tx_crc #(.CHAR_W(CHAR_W), .LEN_W(LEN_W), .CRC_W(CRC_W),
                 .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) crc_i (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr | chan_rst), .add(crc_add),
      .data(dec_data), .len(dec_len), .crc(crc_val));

   always_comb begin
      sh_n    = sh;
      cnt_n   = cnt;
      kind_n  = kind;
      pend_n  = pend;
      out_bit = 1'b1;
      take    = 1'b0;
      crc_add = 1'b0;
      crc_clr = 1'b0;
      if (bit_en) begin
         if (kind == K_CRC && cnt != '0 && !tx_en_q) begin
            // trailer abandoned: a sync byte takes its place
            out_bit = SYNC_CHAR[0];
            sh_n    = SH_W'(SYNC_CHAR) >> 1;
            cnt_n   = CNT_W'(CHAR_W - 1);
            kind_n  = K_SYNC;
            crc_clr = 1'b1;
            pend_n  = 1'b0;
         end else if (cnt != '0) begin
            out_bit = sh[0];
            sh_n    = sh >> 1;
            cnt_n   = cnt - CNT_W'(1);
         end else if (tx_en_q) begin
            if (buf_full) begin
               take    = 1'b1;
               out_bit = dec_data[0];
               sh_n    = SH_W'(dec_data) >> 1;
               cnt_n   = CNT_W'(dec_len - LEN_W'(1));
               kind_n  = K_DATA;
               crc_add = crc_en_q;
               pend_n  = pend | crc_en_q;
            end else if (crc_en_q && pend) begin
               out_bit = crc_val[0];
               sh_n    = SH_W'(crc_val) >> 1;
               cnt_n   = CNT_W'(CRC_W - 1);
               kind_n  = K_CRC;
               crc_clr = 1'b1;
               pend_n  = 1'b0;
            end else begin
               out_bit = SYNC_CHAR[0];
               sh_n    = SH_W'(SYNC_CHAR) >> 1;
               cnt_n   = CNT_W'(CHAR_W - 1);
               kind_n  = K_SYNC;
            end
         end else begin
            kind_n = K_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q   <= 1'b0;
         brk_q     <= 1'b0;
         crc_en_q  <= 1'b0;
         len_sel_q <= 2'd0;
         sh        <= '0;
         cnt       <= '0;
         kind      <= K_IDLE;
         pend      <= 1'b0;
         txd_q     <= 1'b1;
      end else if (chan_rst) begin
         tx_en_q   <= 1'b0;
         brk_q     <= 1'b0;
         crc_en_q  <= 1'b0;
         len_sel_q <= 2'd0;
         sh        <= '0;
         cnt       <= '0;
         kind      <= K_IDLE;
         pend      <= 1'b0;
         txd_q     <= 1'b1;
      end else begin
         if (ctl_wr) begin
            tx_en_q   <= ctl_tx_en;
            brk_q     <= ctl_brk;
            crc_en_q  <= ctl_crc_en;
            len_sel_q <= ctl_len_sel;
         end
         if (bit_en) begin
            sh    <= sh_n;
            cnt   <= cnt_n;
            kind  <= kind_n;
            pend  <= pend_n;
            txd_q <= brk_q ? 1'b0 : out_bit;
         end
      end
   end

   assign txd       = txd_q;
   assign buf_empty = !buf_full;

   AST_BREAK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && brk_q && !chan_rst) |=> !txd); // R4
   AST_IDLE_MARKS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !brk_q && !tx_en_q && cnt == '0 && !chan_rst) |=> txd); // R1
   AST_CRC_ABANDON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !chan_rst && kind == K_CRC && cnt != '0 && !tx_en_q)
      |=> (kind == K_SYNC && cnt == CNT_W'(CHAR_W - 1))); // R9
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_len >= LEN_W'(1) && dec_len <= LEN_W'(CHAR_W))); // R3
   AST_DISABLE_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !chan_rst && kind == K_DATA && cnt > CNT_W'(1) && !tx_en_q)
      |=> (kind == K_DATA && cnt == $past(cnt) - CNT_W'(1))); // R5
endmodule

// File: tb/sync_tx_engine_tb.sv
module sync_tx_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_rst = 1'b0;
   logic       bit_en = 1'b0;
   logic       ctl_wr = 1'b0;
   logic       ctl_tx_en = 1'b0;
   logic       ctl_brk = 1'b0;
   logic       ctl_crc_en = 1'b0;
   logic [1:0] ctl_len_sel = 2'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       buf_empty, txd;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_tx_engine dut_i (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .bit_en(bit_en),
      .ctl_wr(ctl_wr), .ctl_tx_en(ctl_tx_en), .ctl_brk(ctl_brk),
      .ctl_crc_en(ctl_crc_en), .ctl_len_sel(ctl_len_sel),
      .wr_en(wr_en), .wr_data(wr_data), .buf_empty(buf_empty), .txd(txd));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= WATCHDOG && !done) begin
         done = 1'b1;
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic ctl(input logic en, input logic brk, input logic crc, input logic [1:0] sel);
      ctl_wr = 1'b1; ctl_tx_en = en; ctl_brk = brk; ctl_crc_en = crc; ctl_len_sel = sel;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic put(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bits(input int n, output logic [15:0] v);
      v = '0;
      for (int i = 0; i < n; i++) begin
         bit_en = 1'b1;
         @(negedge clk);
         bit_en = 1'b0;
         v[i] = txd;
      end
   endtask

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d, input int n);
      logic [15:0] r = c;
      for (int i = 0; i < n; i++) begin
         logic fb = r[15] ^ d[i];
         r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
      return r;
   endfunction

   function automatic logic [15:0] ones(input int n);
      return 16'((32'd1 << n) - 1);
   endfunction

   task automatic hw_reset();
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] v, v2, c;
      @(negedge clk);
      hw_reset();
      chk("R11 reset txd", 16'(txd), 16'h1);
      chk("R11 reset buf_empty", 16'(buf_empty), 16'h1);

      // R1: disabled line marks high
      ctl(1'b0, 1'b0, 1'b0, 2'd3);
      bits(4, v);
      chk("R1 idle ones", v, 16'h000F);

      // R2: direct lengths, LSB first
      for (int sel = 1; sel <= 3; sel++) begin
         ctl(1'b1, 1'b0, 1'b0, 2'(sel));
         for (int b = 0; b < 256; b += (sel == 3 ? 1 : 37)) begin
            put(8'(b));
            bits(sel + 5, v);
            chk($sformatf("R2 len%0d byte %02h", sel + 5, b), v, 16'(b) & ones(sel + 5));
         end
      end

      // R3: marker-coded lengths, every byte value
      ctl(1'b1, 1'b0, 1'b0, 2'd0);
      for (int b = 0; b < 256; b++) begin
         int lead = 0;
         int n;
         while (lead < 4 && b[7 - lead]) lead++;
         n = 5 - lead;
         put(8'(b));
         bits(n, v);
         chk($sformatf("R3 byte %02h len %0d", b, n), v, 16'(b) & ones(n));
      end

      // R7: underrun without CRC gives sync bytes
      ctl(1'b1, 1'b0, 1'b0, 2'd3);
      bits(8, v);
      chk("R7 sync byte", v, 16'h007E);
      bits(8, v);
      chk("R7 repeated sync byte", v, 16'h007E);

      // R6: CRC trailer over two bytes, then preset again
      ctl(1'b1, 1'b0, 1'b1, 2'd3);
      put(8'h31); bits(8, v);
      put(8'h32); bits(8, v);
      c = crc_upd(crc_upd(16'hFFFF, 8'h31, 8), 8'h32, 8);
      bits(16, v);
      chk("R6 crc trailer 31 32", v, c);
      bits(8, v);
      chk("R6 R7 sync after trailer", v, 16'h007E);
      put(8'hA5); bits(8, v);
      bits(16, v);
      chk("R6 crc from preset", v, crc_upd(16'hFFFF, 8'hA5, 8));

      // R8: inclusion latched at load
      put(8'h11); bits(8, v);
      ctl(1'b1, 1'b0, 1'b0, 2'd3);
      put(8'h22); bits(1, v);
      ctl(1'b1, 1'b0, 1'b1, 2'd3);
      bits(7, v2);
      chk("R8 excluded char still sent", {v2[14:0], v[0]}, 16'h0022);
      bits(16, v);
      chk("R8 crc skips late char", v, crc_upd(16'hFFFF, 8'h11, 8));

      // R6: CRC enable off at underrun sends sync; trailer waits
      put(8'h44); bits(8, v);
      ctl(1'b1, 1'b0, 1'b0, 2'd3);
      bits(8, v);
      chk("R6 no trailer when disabled", v, 16'h007E);
      ctl(1'b1, 1'b0, 1'b1, 2'd3);
      bits(16, v);
      chk("R6 trailer when re-enabled", v, crc_upd(16'hFFFF, 8'h44, 8));

      // R5: disable mid character
      ctl(1'b1, 1'b0, 1'b0, 2'd3);
      bits(8, v);
      put(8'hB6); bits(3, v);
      ctl(1'b0, 1'b0, 1'b0, 2'd3);
      bits(8, v2);
      chk("R5 character completes", {v2[7:0], v[2:0]} & 16'h07FF, 16'h0700 | 16'h00B6);

      // R9: disable during CRC trailer
      ctl(1'b1, 1'b0, 1'b1, 2'd3);
      put(8'h5A); bits(8, v);
      c = crc_upd(16'hFFFF, 8'h5A, 8);
      bits(4, v);
      chk("R9 trailer start", v, c & 16'h000F);
      ctl(1'b0, 1'b0, 1'b1, 2'd3);
      bits(8, v);
      chk("R9 sync replaces crc", v, 16'h007E);
      bits(2, v);
      chk("R9 idle after sync", v, 16'h0003);
      ctl(1'b1, 1'b0, 1'b1, 2'd3);
      put(8'h01); bits(8, v);
      bits(16, v);
      chk("R9 crc preset after abandon", v, crc_upd(16'hFFFF, 8'h01, 8));

      // R4: break over data and while disabled
      ctl(1'b1, 1'b0, 1'b0, 2'd3);
      bits(8, v);
      put(8'hFF); bits(2, v);
      chk("R4 before break", v, 16'h0003);
      ctl(1'b1, 1'b1, 1'b0, 2'd3);
      bits(3, v);
      chk("R4 break zeros", v, 16'h0000);
      ctl(1'b1, 1'b0, 1'b0, 2'd3);
      bits(3, v);
      chk("R4 shift resumes", v, 16'h0007);
      ctl(1'b0, 1'b1, 1'b0, 2'd3);
      bits(8, v);
      bits(4, v);
      chk("R4 break while disabled", v, 16'h0000);
      ctl(1'b0, 1'b0, 1'b0, 2'd3);
      bits(2, v);
      chk("R4 release to idle", v, 16'h0003);

      // R10: holding buffer full, second write ignored
      chk("R10 empty before write", 16'(buf_empty), 16'h1);
      put(8'h3C);
      chk("R10 full after write", 16'(buf_empty), 16'h0);
      put(8'hC3);
      chk("R10 still full", 16'(buf_empty), 16'h0);
      ctl(1'b1, 1'b0, 1'b0, 2'd3);
      bits(8, v);
      chk("R10 first byte kept", v, 16'h003C);
      chk("R10 empty after load", 16'(buf_empty), 16'h1);
      ctl(1'b0, 1'b0, 1'b0, 2'd3);
      bits(8, v);
      bits(2, v);
      chk("R10 dropped byte absent", v, 16'h0003);

      // R11: channel reset
      ctl(1'b1, 1'b1, 1'b0, 2'd3);
      put(8'h00);
      chan_rst = 1'b1;
      @(negedge clk);
      chan_rst = 1'b0;
      chk("R11 chan reset buffer", 16'(buf_empty), 16'h1);
      bits(3, v);
      chk("R11 chan reset enable and break", v, 16'h0007);

      // R11: hardware reset mid character
      ctl(1'b1, 1'b1, 1'b0, 2'd3);
      put(8'h00); bits(2, v);
      put(8'h00);
      hw_reset();
      chk("R11 hw reset buffer", 16'(buf_empty), 16'h1);
      bits(3, v);
      chk("R11 hw reset enable and break", v, 16'h0007);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule